// File: doc/BRIEF.md
# Serial-to-Register-Bus Bridge

This block is an SPI target in mode 0 (clock idle low, data captured on the rising edge and changed on the falling edge) with 8-bit framing. It gives an external host read and write access to 32-bit registers that sit on an internal, word-addressed request/acknowledge bus. A frame opens with a 24-bit header, sent most significant bit first. The top header bit selects write (1) or read (0), and the remaining 23 bits give the word address, which is the byte address divided by four. A write frame carries 32 data bits right after the header. A read frame carries the header, then a host-chosen number of padding bytes, then 32 data bits that the target drives.

The padding exists because an internal access can be slow. The internal read is launched as soon as the header ends, so the padding buys about eight serial clocks per byte before the first data bit is due. If the acknowledge has not arrived by then, a sticky status bit records that the serial clock outran the register access. The header is always big-endian and MSB first. The byte order and bit order of the payload are chosen by the host.

Three registers are decoded inside the bridge and never reach the internal bus: an interface-control register that holds the payload format, a configuration/status register that holds the padding count, the too-fast flag and the interface identifier, and a self-clearing soft-reset register. The SPI pins are asynchronous and pass through two-flop synchronisers into the system clock domain, so that clock must be many times faster than the serial clock.

Top module: `spireg_bridge`

## Requirements
- R1: The header is 24 bits, shifted in MSB first regardless of payload format; header bit 23 is 1 for write and 0 for read, and bits 22:0 are the word address presented on `bus_addr`.
- R2: In a write frame the 32 data bits follow the header directly, with no padding; a non-local address produces exactly one internal write whose `bus_wdata` is the payload decoded with the current format.
- R3: In a read frame, N padding bytes (content ignored) follow the header, then 32 data bits on `spi_miso`; the internal read is requested as soon as the header completes.
- R4: Payload format code (bits 1:0 of word 0): 00 = little-endian bytes, MSB first; 01 = big-endian bytes, MSB first; 10 = little-endian bytes, LSB first; 11 = big-endian bytes, LSB first. Little-endian sends bits 7:0 first; big-endian sends bits 31:24 first.
- R5: Word 1 reads back as bits 31:24 = 2 (serial interface ID), bit 16 = too-fast flag, bits 3:0 = padding count N, all else 0; its value after reset is 0x02000000.
- R6: The too-fast flag is set when the first read-data bit must be driven before the internal acknowledge has arrived; writing word 1 with bit 16 = 1 clears it.
- R7: Word 0 reads back the 2-bit format in bits 1:0, all other bits 0; its value after reset is 0.
- R8: Writing 1 to bit 0 of word 2 starts a soft reset: `soft_rst` is high and word 2 reads 1 for RST_CYCLES clocks, after which word 2 reads 0 and the format, padding and flag return to 0.
- R9: Reads and writes of words 0, 1 and 2 are served locally and never raise `bus_req`.
- R10: Raising chip select before the 56th bit of a write frame aborts the frame and issues no internal write.
- R11: `bus_req` stays high, with a stable address, until `bus_ack`, and each access raises it once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select (asynchronous) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, registered |
| bus_req | output | 1 | Internal access request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 23 | Internal word address |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata | input | 32 | Internal read data |
| soft_rst | output | 1 | High while a soft reset is in progress |

## Verification
The assertions assume that the serial clock is slow enough for each half period to span several system clocks, and that no new internal access is launched while an earlier one still waits for its acknowledge. They also assume that `bus_ack` is only raised while `bus_req` is high. The stimulus uses a half period of eight system clocks, so every edge clears the synchroniser delay. The bus responder acknowledges only a pending request. The sequence waits for each acknowledge before it starts the next frame, including the reads whose acknowledge is deliberately late. Frames that would straddle the end of a soft reset are avoided, because the payload format can change in the middle of such a frame.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int HDR_BITS  = 24;
  localparam int WORD_BITS = 32;
  localparam int ADDR_W    = HDR_BITS - 1;
  localparam logic [7:0] IFID_SERIAL = 8'd2;

  // Map a register word to its on-wire order (wire bit 31 leaves first).
  // fmt[0]: 1 = big-endian bytes; fmt[1]: 1 = LSB first within each byte.
  // The mapping is its own inverse, so it also decodes received payloads.
  function automatic logic [31:0] wire_order(input logic [31:0] w, input logic [1:0] fmt);
    logic [31:0] t;
    logic [31:0] r;
    t = fmt[0] ? w : {w[7:0], w[15:8], w[23:16], w[31:24]};
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) begin
        r[8*b+i] = fmt[1] ? t[8*b+7-i] : t[8*b+i];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
#(
  parameter int PAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic [PAD_W-1:0]  pad_n,
  input  logic [1:0]        fmt,
  input  logic [31:0]       rd_word,
  output logic              hdr_evt,
  output logic              hdr_we,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              wr_evt,
  output logic [31:0]       wr_data,
  output logic              start_evt,
  output logic              miso
);
  localparam int MAX_BITS = HDR_BITS + 8 * (2**PAD_W - 1) + WORD_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(HDR_BITS + WORD_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] start_at;
  logic [30:0]      rx;
  logic [31:0]      tx;
  logic [31:0]      tx_load;
  logic             in_rd;
  logic             in_wr;

  assign tx_load = wire_order(rd_word, fmt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      start_at  <= '0;
      rx        <= '0;
      tx        <= '0;
      in_rd     <= 1'b0;
      in_wr     <= 1'b0;
      hdr_evt   <= 1'b0;
      hdr_we    <= 1'b0;
      hdr_addr  <= '0;
      wr_evt    <= 1'b0;
      wr_data   <= '0;
      start_evt <= 1'b0;
      miso      <= 1'b0;
    end else begin
      hdr_evt   <= 1'b0;
      wr_evt    <= 1'b0;
      start_evt <= 1'b0;
      if (cs_n) begin
        cnt   <= '0;
        in_rd <= 1'b0;
        in_wr <= 1'b0;
        miso  <= 1'b0;
      end else if (sclk_rise && cnt != CNT_MAX) begin
        rx  <= {rx[29:0], mosi};
        cnt <= cnt + 1'b1;
        if (cnt == HDR_LAST) begin
          hdr_evt  <= 1'b1;
          hdr_we   <= rx[22];
          hdr_addr <= {rx[21:0], mosi};
          in_rd    <= ~rx[22];
          in_wr    <= rx[22];
          start_at <= CNT_W'(HDR_BITS) + (CNT_W'(pad_n) << 3);
        end
        if (in_wr && cnt == WR_LAST) begin
          wr_evt  <= 1'b1;
          wr_data <= wire_order({rx, mosi}, fmt);
        end
      end else if (sclk_fall && in_rd) begin
        if (cnt == start_at) begin
          miso      <= tx_load[31];
          tx        <= {tx_load[30:0], 1'b0};
          start_evt <= 1'b1;
        end else if (cnt > start_at) begin
          miso <= tx[31];
          tx   <= {tx[30:0], 1'b0};
        end
      end
    end
  end

  AST_HDR_COUNT: assert property (@(posedge clk) disable iff (rst)
    hdr_evt |-> cnt == CNT_W'(HDR_BITS)); // R1
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_evt, wr_evt, start_evt})); // R3
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !wr_evt && !start_evt); // R10
endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
  import spireg_pkg::*;
#(
  parameter int PAD_W       = 4,
  parameter int RST_CYCLES  = 4096,
  parameter int IFCTRL_ADDR = 0,
  parameter int CFG_ADDR    = 1,
  parameter int SRST_ADDR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_evt,
  input  logic              hdr_we,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              wr_evt,
  input  logic [31:0]       wr_data,
  input  logic              start_evt,
  output logic [1:0]        fmt,
  output logic [PAD_W-1:0]  pad_n,
  output logic [31:0]       rd_word,
  output logic              rd_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              soft_rst
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_IFC  = ADDR_W'(IFCTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(SRST_ADDR);

  logic            slow_q;
  logic [RC_W-1:0] rst_cnt;
  logic [31:0]     local_val;

  function automatic logic is_local(input logic [ADDR_W-1:0] a);
    return (a == A_IFC) || (a == A_CFG) || (a == A_SRST);
  endfunction

  always_comb begin
    local_val = '0;
    if (hdr_addr == A_IFC) begin
      local_val[1:0] = fmt;
    end else if (hdr_addr == A_CFG) begin
      local_val[31:24]     = IFID_SERIAL;
      local_val[16]        = slow_q;
      local_val[PAD_W-1:0] = pad_n;
    end else if (hdr_addr == A_SRST) begin
      local_val[0] = soft_rst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt       <= '0;
      pad_n     <= '0;
      slow_q    <= 1'b0;
      rd_word   <= '0;
      rd_ready  <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      soft_rst  <= 1'b0;
      rst_cnt   <= '0;
    end else begin
      if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        if (!bus_we) begin
          rd_word  <= bus_rdata;
          rd_ready <= 1'b1;
        end
      end
      if (hdr_evt && !hdr_we) begin
        if (is_local(hdr_addr)) begin
          rd_word  <= local_val;
          rd_ready <= 1'b1;
        end else begin
          rd_word  <= '0;
          rd_ready <= 1'b0;
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_addr <= hdr_addr;
        end
      end
      if (start_evt && !rd_ready) slow_q <= 1'b1;
      if (wr_evt) begin
        if (!is_local(hdr_addr)) begin
          bus_req   <= 1'b1;
          bus_we    <= 1'b1;
          bus_addr  <= hdr_addr;
          bus_wdata <= wr_data;
        end else if (hdr_addr == A_IFC) begin
          fmt <= wr_data[1:0];
        end else if (hdr_addr == A_CFG) begin
          pad_n <= wr_data[PAD_W-1:0];
          if (wr_data[16]) slow_q <= 1'b0;
        end
      end
      if (wr_evt && hdr_addr == A_SRST && wr_data[0]) begin
        soft_rst <= 1'b1;
        rst_cnt  <= RC_W'(RST_CYCLES - 1);
      end else if (soft_rst) begin
        if (rst_cnt == '0) begin
          soft_rst <= 1'b0;
          fmt      <= '0;
          pad_n    <= '0;
          slow_q   <= 1'b0;
        end else begin
          rst_cnt <= rst_cnt - 1'b1;
        end
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr)); // R11
  AST_LOCAL_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !is_local(bus_addr)); // R9
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $fell(soft_rst) |-> fmt == 2'b00 && pad_n == '0 && !slow_q); // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_q) |-> $past(start_evt && !rd_ready)); // R6
endmodule

// File: rtl/spireg_bridge.sv
module spireg_bridge
  import spireg_pkg::*;
#(
  parameter int PAD_W      = 4,
  parameter int RST_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              soft_rst
);
  logic [2:0]        pins_s;
  logic              sclk_q;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              hdr_evt;
  logic              hdr_we;
  logic [ADDR_W-1:0] hdr_addr;
  logic              wr_evt;
  logic [31:0]       wr_data;
  logic              start_evt;
  logic [1:0]        fmt;
  logic [PAD_W-1:0]  pad_n;
  logic [31:0]       rd_word;
  logic              rd_ready;

  spireg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= pins_s[1];
  end

  assign sclk_rise = pins_s[1] & ~sclk_q;
  assign sclk_fall = ~pins_s[1] & sclk_q;

  spireg_frame #(.PAD_W(PAD_W)) u_frame (
    .clk(clk), .rst(rst),
    .cs_n(pins_s[2]), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(pins_s[0]),
    .pad_n(pad_n), .fmt(fmt), .rd_word(rd_word),
    .hdr_evt(hdr_evt), .hdr_we(hdr_we), .hdr_addr(hdr_addr),
    .wr_evt(wr_evt), .wr_data(wr_data), .start_evt(start_evt),
    .miso(spi_miso)
  );

  spireg_ctrl #(.PAD_W(PAD_W), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst),
    .hdr_evt(hdr_evt), .hdr_we(hdr_we), .hdr_addr(hdr_addr),
    .wr_evt(wr_evt), .wr_data(wr_data), .start_evt(start_evt),
    .fmt(fmt), .pad_n(pad_n), .rd_word(rd_word), .rd_ready(rd_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .soft_rst(soft_rst)
  );
endmodule

// File: tb/spireg_bridge_test.sv
module spireg_bridge_test;
  localparam int HP   = 8;
  localparam int RSTC = 4096;

  typedef struct packed {
    logic        we;
    logic [22:0] addr;
    logic [31:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic bus_req, bus_we, soft_rst;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int vec = 0;
  int err = 0;
  int lat = 4;
  logic [1:0] b_fmt = 2'b00;
  int b_pad = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  spireg_bridge #(.PAD_W(4), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .soft_rst(soft_rst)
  );

  function automatic logic [31:0] bus_model(input logic [22:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8], a[22:16], 1'b1, ~a[7:0]};
  endfunction

  function automatic logic [31:0] enc(input logic [31:0] w, input logic [1:0] f);
    logic [31:0] o;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = f[0] ? 3 - k : k;
      for (int j = 0; j < 8; j++) o[31-(8*k+j)] = w[8*idx + (f[1] ? j : 7 - j)];
    end
    return o;
  endfunction

  function automatic logic [31:0] dec(input logic [31:0] s, input logic [1:0] f);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = f[0] ? 3 - k : k;
      for (int j = 0; j < 8; j++) w[8*idx + (f[1] ? j : 7 - j)] = s[31-(8*k+j)];
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_frame(input logic [191:0] s, input int nbits, input int rx_from,
                             input int stop_at, output logic [31:0] rx);
    rx = '0;
    spi_cs_n = 1'b0;
    ticks(HP);
    for (int i = 0; i < nbits; i++) begin
      if (i == stop_at) break;
      spi_mosi = s[191-i];
      ticks(HP);
      if (i >= rx_from && i < rx_from + 32) rx[31-(i-rx_from)] = spi_miso;
      spi_sclk = 1'b1;
      ticks(HP);
      spi_sclk = 1'b0;
    end
    ticks(HP);
    spi_cs_n = 1'b1;
    ticks(3*HP);
  endtask

  task automatic spi_write(input logic [22:0] a, input logic [31:0] d, input int stop_at);
    logic [191:0] s;
    logic [31:0] dummy;
    s = '0;
    s[191:136] = {1'b1, a, enc(d, b_fmt)};
    if (a > 23'd2 && stop_at >= 56) q.push_back('{1'b1, a, d});
    shift_frame(s, 56, 1000, stop_at, dummy);
    ticks(lat + 4);
  endtask

  task automatic spi_read(input logic [22:0] a, output logic [31:0] d);
    logic [191:0] s;
    logic [31:0] rx;
    s = '0;
    s[191:168] = {1'b0, a};
    for (int i = 24; i < 24 + 8*b_pad; i++) s[191-i] = 1'b1;
    if (a > 23'd2) q.push_back('{1'b0, a, 32'h0});
    shift_frame(s, 56 + 8*b_pad, 24 + 8*b_pad, 1000, rx);
    d = dec(rx, b_fmt);
    ticks(lat + 4);
  endtask

  // Bus responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req) begin
        if (q.size() == 0) begin
          chk("R9/R10 unexpected bus request addr", {9'h0, bus_addr}, 32'hFFFFFFFF);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R1 bus address", {9'h0, bus_addr}, {9'h0, e.addr});
          chk("R1 bus direction", {31'h0, bus_we}, {31'h0, e.we});
          if (e.we) chk("R2 bus write data", bus_wdata, e.data);
        end
        repeat (lat) @(negedge clk);
        chk("R11 request held until ack", {31'h0, bus_req}, 32'h1);
        bus_rdata = bus_model(bus_addr);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    ticks(5);
    rst = 1'b0;
    ticks(5);
    chk("R5 reset miso", {31'h0, spi_miso}, 32'h0);
    chk("R11 reset bus_req", {31'h0, bus_req}, 32'h0);
    chk("R8 reset soft_rst", {31'h0, soft_rst}, 32'h0);
    spi_read(23'd1, d);  chk("R5 cfgstat after reset", d, 32'h02000000);
    spi_read(23'd0, d);  chk("R7 ifctrl after reset", d, 32'h0);

    spi_write(23'h123456, 32'hDEADBEEF, 1000);                 // R1 R2, format 00
    spi_write(23'd1, 32'h00000001, 1000); b_pad = 1;           // R5 padding 1
    spi_read(23'd1, d);  chk("R5 cfgstat pad 1", d, 32'h02000001);
    lat = 4;
    spi_read(23'h000100, d); chk("R3 read data fmt 00", d, bus_model(23'h000100));

    for (int f = 1; f < 4; f++) begin
      logic [1:0] ff;
      ff = 2'(f);
      spi_write(23'd0, {4{6'b0, ff}}, 1000); b_fmt = ff;       // R4 repeated code
      spi_read(23'd0, d); chk("R7 ifctrl readback", d, {30'h0, ff});
      spi_write(23'h4A5B6C + 23'(f), 32'h1234ABCD ^ {8{4'(f)}}, 1000);
      spi_read(23'h2C0F10 + 23'(f), d);
      chk("R4 read data in format", d, bus_model(23'h2C0F10 + 23'(f)));
    end
    spi_read(23'd1, d); chk("R6 flag clear before slow reads", d, 32'h02000001);

    // too-fast cases, format stays 11
    spi_write(23'd1, 32'h0, 1000); b_pad = 0;
    lat = 40;
    spi_read(23'h000777, d);
    spi_read(23'd1, d); chk("R6 flag set pad 0 lat 40", d, 32'h02010000);
    spi_write(23'd1, 32'h00010001, 1000); b_pad = 1;
    spi_read(23'd1, d); chk("R6 flag cleared by write", d, 32'h02000001);
    lat = 200;
    spi_read(23'h000778, d);
    spi_read(23'd1, d); chk("R6 flag set pad 1 lat 200", d, 32'h02010001);
    spi_write(23'd1, 32'h00010002, 1000); b_pad = 2;
    spi_read(23'h000779, d); chk("R3 read data pad 2", d, bus_model(23'h000779));
    spi_read(23'd1, d); chk("R6 flag stays clear pad 2 lat 200", d, 32'h02000002);
    lat = 4;

    // abort mid-frame
    spi_write(23'h0ABCDE, 32'hCAFEF00D, 40);
    chk("R10 no request after abort", {31'h0, bus_req}, 32'h0);
    spi_read(23'h0ABCDE, d); chk("R10 recovery after abort", d, bus_model(23'h0ABCDE));

    // soft reset while format 11 and padding 2
    spi_write(23'd2, 32'h00000001, 1000);
    chk("R8 soft_rst high", {31'h0, soft_rst}, 32'h1);
    spi_read(23'd2, d); chk("R8 srst reads 1 during reset", d, 32'h1);
    ticks(RSTC + 200);
    b_fmt = 2'b00; b_pad = 0;
    chk("R8 soft_rst low after", {31'h0, soft_rst}, 32'h0);
    spi_read(23'd2, d); chk("R8 srst reads 0 after", d, 32'h0);
    spi_read(23'd0, d); chk("R8 format default", d, 32'h0);
    spi_read(23'd1, d); chk("R8 cfgstat default", d, 32'h02000000);

    ticks(50);
    chk("R9 scoreboard drained", q.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule